// File: doc/BRIEF.md
# Write-Masked PHY Control Register Bank

This block is a small register bank that holds the static control settings of a storage-interface PHY. It has seven 32-bit control words and one read-only status word behind a simple synchronous port. Each write carries its own per-bit enable mask. The upper half-word of the write data says which bits of the lower half-word are taken, so software can change one field without first reading the register back.

Two of the control words drive dedicated outputs. The word at byte offset 0x18 carries the analog power enable, the DLL enable and the pad drive-strength code. The word at offset 0x00 carries the DLL frequency band and the output tap-delay controls. The status word at 0x20 shows two live inputs from the PHY: calibration complete and DLL locked.

The address decoder sorts every access into one of three kinds: control, status or none. The registered read path is a single `unique case` over that kind. A read always has one cycle of latency.

Top module: `phy_ctrl_bank`

## Requirements
- R1: On a write to a control offset, lower data bit x is stored exactly when bit x+16 of the same write word is 1.
- R2: A lower bit whose enable bit is 0 keeps its previous value. A write whose upper half-word is all zero leaves the register unchanged.
- R3: The seven control registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. A write to one of them never changes another.
- R4: Reset is asynchronous and active low. It clears every control bit to 0, so `pwr_on` and `dll_en` are 0 (powered down, DLL off) and reads return 0.
- R5: In the register at 0x18, bit 0 drives `pwr_on` (1 = powered on) and bit 1 drives `dll_en`. Bits 6:4 drive `drive_sel`, with codes 0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm and 4 = 40 ohm.
- R6: In the register at 0x00, bits 13:12 drive `freq_band` (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz), bit 11 drives `otap_en`, and bits 10:7 drive `otap_val`.
- R7: A read asserted in cycle n shows its data on `rdata` after the clock edge that ends cycle n. A control read returns the stored lower 16 bits with bits 31:16 equal to 0. `rdata` holds its value in cycles with no read.
- R8: A read at offset 0x20 returns `cal_done` in bit 6 and `dll_ready` in bit 5, both active high, with all other bits 0. Both inputs are sampled in the read cycle.
- R9: Writes to 0x20, to unlisted offsets (for example 0x1C and 0x24) and to offsets that are not word aligned change no register. Reads of unlisted or unaligned offsets return 0.
- R10: A read and a write to the same control register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte offset of the access |
| wdata | input | 32 | Write word: bits 31:16 are enables, bits 15:0 are data |
| rdata | output | 32 | Registered read data |
| cal_done | input | 1 | PHY calibration complete |
| dll_ready | input | 1 | PHY DLL locked |
| pwr_on | output | 1 | Analog power enable |
| dll_en | output | 1 | DLL enable |
| drive_sel | output | 3 | Pad drive-strength code |
| freq_band | output | 2 | DLL frequency band |
| otap_en | output | 1 | Output tap-delay enable |
| otap_val | output | 4 | Output tap-delay value |

## Verification
The bench writes words whose enable half and data half disagree: set data bits with no enable, enable bits with zero data, and a write with no enables at all. A bank that ignored the mask, or that applied it to the wrong half, would return values other than the hand-computed ones. It then writes all ones to 0x1C, 0x24, 0x19 and the status offset. A decoder that kept only some address bits, or that let status writes through, would corrupt the 0x18 word or another control word, and the re-reads would show this. A read issued in the same cycle as a write to that register catches a read path that forwards the new value. Status reads with the two inputs in different combinations catch swapped or misplaced status bits.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
    localparam int STATUS_OFS = 32;   // byte offset 0x20
    // Field placement inside the power word
    localparam int PWR_REG    = 6;    // word index of offset 0x18
    localparam int PWR_BIT    = 0;
    localparam int DLL_BIT    = 1;
    localparam int DRV_LSB    = 4;
    localparam int DRV_W      = 3;
    // Field placement inside the timing word
    localparam int TAP_REG    = 0;    // word index of offset 0x00
    localparam int OTVAL_LSB  = 7;
    localparam int OTVAL_W    = 4;
    localparam int OTEN_BIT   = 11;
    localparam int BAND_LSB   = 12;
    localparam int BAND_W     = 2;
    // Status word
    localparam int CAL_BIT    = 6;
    localparam int LOCK_BIT   = 5;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_CTRL   = 2'd1,
        ACC_STATUS = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/pcb_addr_decode.sv
module pcb_addr_decode
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_CTRL = 7,
    parameter int IDX_W    = $clog2(NUM_CTRL)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] CTRL_LIMIT = WORD_W'(NUM_CTRL);
    localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(STATUS_OFS);

    logic [WORD_W-1:0] word;
    logic              aligned;

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign idx     = word[IDX_W-1:0];

    always_comb begin
        if (aligned && (word < CTRL_LIMIT)) begin
            kind = ACC_CTRL;
        end else if (addr == STAT_ADDR) begin
            kind = ACC_STATUS;
        end else begin
            kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/pcb_mask_reg.sv
module pcb_mask_reg #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [2*HALF_W-1:0]   wdata,
    output logic [HALF_W-1:0]     q
);
    logic [HALF_W-1:0] bit_en;
    logic [HALF_W-1:0] bit_val;

    assign bit_en  = wdata[2*HALF_W-1:HALF_W];
    assign bit_val = wdata[HALF_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~bit_en) | (bit_val & bit_en);
        end
    end

    // R1
    enabled_bits_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q ^ $past(bit_val)) & $past(bit_en)) == '0);

    // R2
    masked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q ^ $past(q)) & ~$past(bit_en)) == '0);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/phy_ctrl_bank.sv
module phy_ctrl_bank
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_CTRL = 7,
    parameter int WORD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              cal_done,
    input  logic              dll_ready,
    output logic              pwr_on,
    output logic              dll_en,
    output logic [DRV_W-1:0]  drive_sel,
    output logic [BAND_W-1:0] freq_band,
    output logic              otap_en,
    output logic [OTVAL_W-1:0] otap_val
);
    localparam int HALF_W = WORD_W / 2;
    localparam int IDX_W  = $clog2(NUM_CTRL);

    acc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [HALF_W-1:0]  ctrl_q [NUM_CTRL];
    logic [WORD_W-1:0]  status_word;

    pcb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CTRL (NUM_CTRL),
        .IDX_W    (IDX_W)
    ) u_dec (
        .addr (addr),
        .kind (kind),
        .idx  (idx)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
        logic we_i;
        assign we_i = wr_en && (kind == ACC_CTRL) && (idx == IDX_W'(i));
        pcb_mask_reg #(.HALF_W(HALF_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_i),
            .wdata (wdata),
            .q     (ctrl_q[i])
        );
    end

    always_comb begin
        status_word           = '0;
        status_word[CAL_BIT]  = cal_done;
        status_word[LOCK_BIT] = dll_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (kind)
                ACC_CTRL:   rdata <= {{HALF_W{1'b0}}, ctrl_q[idx]};
                ACC_STATUS: rdata <= status_word;
                ACC_NONE:   rdata <= '0;
                default:    rdata <= '0;
            endcase
        end
    end

    assign pwr_on    = ctrl_q[PWR_REG][PWR_BIT];
    assign dll_en    = ctrl_q[PWR_REG][DLL_BIT];
    assign drive_sel = ctrl_q[PWR_REG][DRV_LSB +: DRV_W];
    assign freq_band = ctrl_q[TAP_REG][BAND_LSB +: BAND_W];
    assign otap_en   = ctrl_q[TAP_REG][OTEN_BIT];
    assign otap_val  = ctrl_q[TAP_REG][OTVAL_LSB +: OTVAL_W];

    // R7
    upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[WORD_W-1:HALF_W] == '0);

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R8
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_STATUS) |=>
            (rdata[CAL_BIT] == $past(cal_done)) &&
            (rdata[LOCK_BIT] == $past(dll_ready)) &&
            ($countones(rdata) <= 2));

    // R9
    undefined_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_NONE) |=> rdata == '0);

    // R9
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind != ACC_CTRL) |=> $stable(pwr_on) && $stable(dll_en) &&
            $stable(drive_sel) && $stable(freq_band) && $stable(otap_val));
endmodule

// File: tb/tb_phy_ctrl_bank.sv
module tb_phy_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cal_done = 1'b0;
    logic        dll_ready = 1'b0;
    logic        pwr_on, dll_en, otap_en;
    logic [2:0]  drive_sel;
    logic [1:0]  freq_band;
    logic [3:0]  otap_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    phy_ctrl_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cal_done(cal_done), .dll_ready(dll_ready),
        .pwr_on(pwr_on), .dll_en(dll_en), .drive_sel(drive_sel),
        .freq_band(freq_band), .otap_en(otap_en), .otap_val(otap_val)
    );

    // {addr, write word, expected lower half on read-back}
    localparam int NVEC = 16;
    localparam logic [53:0] VECS [NVEC] = '{
        {6'h18, 32'h0001_0001, 16'h0001},   // R5 power on
        {6'h18, 32'h0002_FFFF, 16'h0003},   // R1 only bit 1 enabled
        {6'h18, 32'h0070_0040, 16'h0043},   // R5 drive code 4
        {6'h18, 32'h0000_FFFF, 16'h0043},   // R2 no enables
        {6'h18, 32'h0001_0000, 16'h0042},   // R1 clear power
        {6'h00, 32'h3000_1000, 16'h1000},   // R6 band 1
        {6'h00, 32'h0800_0800, 16'h1800},   // R6 tap enable
        {6'h00, 32'h0780_0200, 16'h1A00},   // R6 tap value 4
        {6'h04, 32'hFFFF_A5A5, 16'hA5A5},   // R3
        {6'h08, 32'h00FF_1234, 16'h0034},   // R3 low byte only
        {6'h0C, 32'hFF00_ABCD, 16'hAB00},   // R3 high byte only
        {6'h10, 32'hFFFF_FFFF, 16'hFFFF},   // R3
        {6'h14, 32'h0F0F_FFFF, 16'h0F0F},   // R3
        {6'h04, 32'h00F0_0000, 16'hA505},   // R2 clear one nibble
        {6'h1C, 32'hFFFF_FFFF, 16'h0000},   // R9 unlisted
        {6'h24, 32'hFFFF_FFFF, 16'h0000}    // R9 unlisted
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] r);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        r = rdata;
    endtask

    initial begin
        logic [31:0] r;
        // R4 reset state
        repeat (3) @(negedge clk);
        check("R4 rdata in reset", rdata, 32'h0);
        check("R4 pwr_on/dll_en", {30'h0, pwr_on, dll_en}, 32'h0);
        rst_n = 1'b1;
        do_read(6'h18, r);
        check("R4 read 0x18", r, 32'h0);
        do_read(6'h00, r);
        check("R4 read 0x00", r, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i][53:48], VECS[i][47:16]);
            do_read(VECS[i][53:48], r);
            check($sformatf("R1/R2/R3 vector %0d", i), r, {16'h0, VECS[i][15:0]});
        end

        // R5 / R6 field outputs
        check("R5 pwr_on", {31'h0, pwr_on}, 32'h0);
        check("R5 dll_en", {31'h0, dll_en}, 32'h1);
        check("R5 drive_sel", {29'h0, drive_sel}, 32'h4);
        check("R6 freq_band", {30'h0, freq_band}, 32'h1);
        check("R6 otap_en", {31'h0, otap_en}, 32'h1);
        check("R6 otap_val", {28'h0, otap_val}, 32'h4);

        // R7 hold between reads
        repeat (4) @(negedge clk);
        check("R7 rdata holds", rdata, 32'h0);

        // R8 status
        cal_done = 1'b1; dll_ready = 1'b0;
        do_read(6'h20, r);
        check("R8 cal only", r, 32'h40);
        cal_done = 1'b0; dll_ready = 1'b1;
        do_read(6'h20, r);
        check("R8 lock only", r, 32'h20);
        cal_done = 1'b1;
        do_read(6'h20, r);
        check("R8 both", r, 32'h60);

        // R9 status and unaligned writes ignored
        do_write(6'h20, 32'hFFFF_FFFF);
        do_write(6'h19, 32'hFFFF_FFFF);
        do_write(6'h02, 32'hFFFF_FFFF);
        do_read(6'h18, r);
        check("R9 0x18 untouched", r, 32'h0042);
        do_read(6'h00, r);
        check("R9 0x00 untouched", r, 32'h1A00);
        do_read(6'h04, r);
        check("R9 0x04 untouched", r, 32'hA505);
        do_read(6'h14, r);
        check("R9 0x14 untouched", r, 32'h0F0F);
        do_read(6'h19, r);
        check("R9 unaligned read", r, 32'h0);
        check("R9 outputs", {pwr_on, dll_en, drive_sel, freq_band, otap_en, otap_val},
              {1'b0, 1'b1, 3'd4, 2'd1, 1'b1, 4'd4});

        // R10 read and write together
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 6'h10; wdata = 32'hFFFF_0000;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 old value", rdata, 32'hFFFF);
        do_read(6'h10, r);
        check("R10 new value", r, 32'h0);

        // R4 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R4 outputs after reset", {pwr_on, dll_en, drive_sel, freq_band, otap_en, otap_val},
              14'h0);
        rst_n = 1'b1;
        do_read(6'h04, r);
        check("R4 0x04 after reset", r, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule